// File: doc/BRIEF.md
# Re-Reference Prediction Replacement Controller

This block keeps the replacement state for a small array of cache sets and picks the way to evict when a set is full. Each way of every set holds a 2-bit prediction of how soon it will be used again. A hit marks its line as needed soon. A fill places the new line at a value that depends on the insertion policy in force. A victim query returns the way predicted to be needed furthest in the future. Tag compare, data storage and miss handling belong to the surrounding cache, which reports hits and fills to this block and asks it for victims.

Three insertion policies are available, selected by a mode input:
- **Static:** protects newly filled lines.
- **Bimodal:** places nearly every new line at the evict-first value.
- **Dynamic:** picks one of the other two at run time. A few leader sets are fixed to each policy. A saturating selector counts the fills (misses) seen in each leader group. All other sets follow the policy whose leaders miss less.

Top module: `rrip_repl_ctrl`

## Requirements
- R1: After reset every way of every set is invalid and `vic_valid` is low. The dynamic-mode selector starts at 511.
- R2: A hit event (`upd_valid`=1, `upd_fill`=0) sets the addressed way's prediction value to 0 at the next clock edge.
- R3: When the queried set holds any invalid way, the victim is the lowest-numbered invalid way, and no prediction value in that set changes.
- R4: When all ways of the queried set are valid, the same amount is added to every way of the set. That amount is 3 minus the largest value, so the largest value becomes 3. The victim is the lowest-numbered way that then holds 3.
- R5: With `mode_sel`=0 (static), a fill event (`upd_valid`=1, `upd_fill`=1) marks the way valid and sets its value to 2.
- R6: With `mode_sel`=1 (bimodal), a fill sets the value to 3, except for one fill in 32. The bimodal policy keeps a fill count that starts at 0 after reset and advances on every fill it handles. The fill that finds this count at a multiple of 32 is set to 2.
- R7: With `mode_sel`=2 (dynamic), leader set membership is fixed by the low three set-index bits:
  - Bits equal to 0: static leader. The set always uses the static policy. Each fill in it increments the 10-bit selector, saturating at 1023.
  - Bits equal to 7: bimodal leader. The set always uses the bimodal policy. Each fill in it decrements the selector, saturating at 0.
  - Any other value: follower. The set uses the bimodal policy when the selector is at least 512, and the static policy otherwise.
  - The selector changes only on fills in dynamic mode.
- R8: A victim query (`vq_valid`=1) produces `vic_valid`=1 with `vic_way` in the next cycle. In any other cycle `vic_valid` is 0. The answer is computed from the state before the query's clock edge. If a hit or fill targets a way at the same edge as a query's aging, the hit or fill value wins for that way.
- R9: `mode_sel`=3 behaves exactly like the static mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Insertion policy: 0 static, 1 bimodal, 2 dynamic, 3 static |
| upd_valid | input | 1 | Hit or fill event this cycle |
| upd_fill | input | 1 | 1 = fill, 0 = hit |
| upd_set | input | 4 | Set index of the event |
| upd_way | input | 2 | Way of the event |
| vq_valid | input | 1 | Victim query this cycle |
| vq_set | input | 4 | Set index of the query |
| vic_valid | output | 1 | Victim answer valid (one cycle after the query) |
| vic_way | output | 2 | Chosen victim way |

## Verification
Every wrong internal value in this block reaches the ports through victim answers, one cycle after the query that reads it. Examples:
- A wrong insertion value, a missed hit clear or a wrong aging amount changes which way is named as victim at a later query on that set.
- A selector that counts wrongly or saturates at the wrong bound only shows up after enough leader fills to move it across 512. The effect then appears as a changed insertion value in a follower set, and is seen at that set's next victim query.

The bench therefore runs long leader-fill sequences in both directions before querying follower sets. It also mixes hits, fills and queries on the same set in the same cycle.

// File: rtl/rrip_pkg.sv
package rrip_pkg;

   typedef enum logic [1:0] {
      MODE_STATIC     = 2'd0,
      MODE_BIMODAL    = 2'd1,
      MODE_DYNAMIC    = 2'd2,
      MODE_STATIC_ALT = 2'd3
   } ins_mode_e;

endpackage

// File: rtl/rrip_victim_pick.sv
module rrip_victim_pick #(
   parameter int NUM_WAYS = 4,
   parameter int RRPV_W   = 2
) (
   input  logic [NUM_WAYS-1:0][RRPV_W-1:0] set_rrpv,
   input  logic [NUM_WAYS-1:0]             set_valid,
   output logic [$clog2(NUM_WAYS)-1:0]     pick_way,
   output logic [RRPV_W-1:0]               age_step
);

   localparam int WAY_W = $clog2(NUM_WAYS);
   localparam logic [RRPV_W-1:0] RRPV_MAX = '1;

   logic              found_inv;
   logic [WAY_W-1:0]  inv_way;
   logic [WAY_W-1:0]  max_way;
   logic [RRPV_W-1:0] top_val;

   // lowest invalid way
   always_comb begin
      found_inv = 1'b0;
      inv_way   = '0;
      for (int w = NUM_WAYS - 1; w >= 0; w--) begin
         if (!set_valid[w]) begin
            found_inv = 1'b1;
            inv_way   = WAY_W'(w);
         end
      end
   end

   // largest value in the set, then the lowest way that holds it
   always_comb begin
      top_val = '0;
      for (int w = 0; w < NUM_WAYS; w++) begin
         if (set_rrpv[w] > top_val) top_val = set_rrpv[w];
      end
      max_way = '0;
      for (int w = NUM_WAYS - 1; w >= 0; w--) begin
         if (set_rrpv[w] == top_val) max_way = WAY_W'(w);
      end
   end

   // the whole repeated aging loop collapses into one add of (max - top)
   assign pick_way = found_inv ? inv_way : max_way;
   assign age_step = found_inv ? '0 : (RRPV_MAX - top_val);

endmodule

// File: rtl/rrip_insert_policy.sv
module rrip_insert_policy
   import rrip_pkg::*;
#(
   parameter int NUM_SETS       = 16,
   parameter int RRPV_W         = 2,
   parameter int PSEL_W         = 10,
   parameter int BIMODAL_PERIOD = 32,
   parameter int LEADER_SEL_W   = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  ins_mode_e                   mode,
   input  logic                        fill_fire,
   input  logic [$clog2(NUM_SETS)-1:0] fill_set,
   output logic [RRPV_W-1:0]           ins_val,
   output logic [PSEL_W-1:0]           psel_q
);

   localparam int BIP_W = $clog2(BIMODAL_PERIOD);
   localparam logic [RRPV_W-1:0] RRPV_MAX  = '1;
   localparam logic [RRPV_W-1:0] RRPV_LONG = RRPV_MAX - 1'b1;
   localparam logic [PSEL_W-1:0] PSEL_INIT = PSEL_W'((1 << (PSEL_W - 1)) - 1);

   logic [LEADER_SEL_W-1:0] grp;
   logic                    sta_leader;
   logic                    bim_leader;
   logic                    use_bim;
   logic [BIP_W-1:0]        bip_q;

   assign grp        = fill_set[LEADER_SEL_W-1:0];
   assign sta_leader = (grp == '0);
   assign bim_leader = (grp == '1);

   always_comb begin
      case (mode)
         MODE_BIMODAL: use_bim = 1'b1;
         MODE_DYNAMIC: use_bim = bim_leader | (~sta_leader & psel_q[PSEL_W-1]);
         default:      use_bim = 1'b0;
      endcase
   end

   assign ins_val = (use_bim && (bip_q != '0)) ? RRPV_MAX : RRPV_LONG;

   // bimodal throttle: one long insertion per period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    bip_q <= '0;
      else if (fill_fire && use_bim) bip_q <= bip_q + 1'b1;
   end

   // dueling selector, counts leader fills (misses)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psel_q <= PSEL_INIT;
      end else if (fill_fire && (mode == MODE_DYNAMIC)) begin
         if (sta_leader && (psel_q != '1))      psel_q <= psel_q + 1'b1;
         else if (bim_leader && (psel_q != '0)) psel_q <= psel_q - 1'b1;
      end
   end

endmodule

// File: rtl/rrip_state_array.sv
module rrip_state_array #(
   parameter int NUM_SETS = 16,
   parameter int NUM_WAYS = 4,
   parameter int RRPV_W   = 2
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      upd_valid,
   input  logic                                      upd_fill,
   input  logic [$clog2(NUM_SETS)-1:0]               upd_set,
   input  logic [$clog2(NUM_WAYS)-1:0]               upd_way,
   input  logic [RRPV_W-1:0]                         ins_val,
   input  logic                                      age_en,
   input  logic [$clog2(NUM_SETS)-1:0]               age_set,
   input  logic [RRPV_W-1:0]                         age_step,
   output logic [NUM_SETS-1:0][NUM_WAYS-1:0][RRPV_W-1:0] rrpv_q,
   output logic [NUM_SETS-1:0][NUM_WAYS-1:0]         valid_q
);

   localparam int SET_W = $clog2(NUM_SETS);
   localparam int WAY_W = $clog2(NUM_WAYS);

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      logic age_me;
      assign age_me = age_en && (age_set == SET_W'(s));

      for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
         logic              touch;
         logic [RRPV_W-1:0] cell_q;
         logic              vld_q;

         assign touch = upd_valid && (upd_set == SET_W'(s)) && (upd_way == WAY_W'(w));

         // an event on this way takes precedence over aging at the same edge
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cell_q <= '1;
               vld_q  <= 1'b0;
            end else if (touch) begin
               cell_q <= upd_fill ? ins_val : '0;
               vld_q  <= vld_q | upd_fill;
            end else if (age_me) begin
               cell_q <= cell_q + age_step;
            end
         end

         assign rrpv_q[s][w] = cell_q;
         assign valid_q[s][w] = vld_q;
      end
   end

endmodule

// File: rtl/rrip_repl_ctrl.sv
module rrip_repl_ctrl
   import rrip_pkg::*;
#(
   parameter int NUM_SETS       = 16,
   parameter int NUM_WAYS       = 4,
   parameter int RRPV_W         = 2,
   parameter int PSEL_W         = 10,
   parameter int BIMODAL_PERIOD = 32,
   parameter int LEADER_SEL_W   = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [1:0]                  mode_sel,
   input  logic                        upd_valid,
   input  logic                        upd_fill,
   input  logic [$clog2(NUM_SETS)-1:0] upd_set,
   input  logic [$clog2(NUM_WAYS)-1:0] upd_way,
   input  logic                        vq_valid,
   input  logic [$clog2(NUM_SETS)-1:0] vq_set,
   output logic                        vic_valid,
   output logic [$clog2(NUM_WAYS)-1:0] vic_way
);

   localparam int SET_W = $clog2(NUM_SETS);
   localparam int WAY_W = $clog2(NUM_WAYS);

   // elaboration-time parameter checks
   if (NUM_WAYS < 2 || (NUM_WAYS & (NUM_WAYS - 1)) != 0) begin : g_bad_ways
      $error("NUM_WAYS must be a power of two, at least 2");
   end
   if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
      $error("NUM_SETS must be a power of two, at least 2");
   end
   if (RRPV_W < 2) begin : g_bad_rrpv
      $error("RRPV_W must be at least 2");
   end
   if (PSEL_W < 2) begin : g_bad_psel
      $error("PSEL_W must be at least 2");
   end
   if (BIMODAL_PERIOD < 2 || (BIMODAL_PERIOD & (BIMODAL_PERIOD - 1)) != 0) begin : g_bad_bip
      $error("BIMODAL_PERIOD must be a power of two, at least 2");
   end
   if (LEADER_SEL_W < 1 || LEADER_SEL_W > SET_W) begin : g_bad_leader
      $error("LEADER_SEL_W must lie in 1..log2(NUM_SETS)");
   end

   logic [NUM_SETS-1:0][NUM_WAYS-1:0][RRPV_W-1:0] rrpv_all;
   logic [NUM_SETS-1:0][NUM_WAYS-1:0]             valid_all;
   logic [PSEL_W-1:0]                             psel_val;
   logic [RRPV_W-1:0]                             ins_val;
   logic [WAY_W-1:0]                              pick_way;
   logic [RRPV_W-1:0]                             age_step;

   rrip_insert_policy #(
      .NUM_SETS      (NUM_SETS),
      .RRPV_W        (RRPV_W),
      .PSEL_W        (PSEL_W),
      .BIMODAL_PERIOD(BIMODAL_PERIOD),
      .LEADER_SEL_W  (LEADER_SEL_W)
   ) i_policy (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (ins_mode_e'(mode_sel)),
      .fill_fire(upd_valid & upd_fill),
      .fill_set (upd_set),
      .ins_val  (ins_val),
      .psel_q   (psel_val)
   );

   rrip_victim_pick #(
      .NUM_WAYS(NUM_WAYS),
      .RRPV_W  (RRPV_W)
   ) i_pick (
      .set_rrpv (rrpv_all[vq_set]),
      .set_valid(valid_all[vq_set]),
      .pick_way (pick_way),
      .age_step (age_step)
   );

   rrip_state_array #(
      .NUM_SETS(NUM_SETS),
      .NUM_WAYS(NUM_WAYS),
      .RRPV_W  (RRPV_W)
   ) i_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_valid(upd_valid),
      .upd_fill (upd_fill),
      .upd_set  (upd_set),
      .upd_way  (upd_way),
      .ins_val  (ins_val),
      .age_en   (vq_valid),
      .age_set  (vq_set),
      .age_step (age_step),
      .rrpv_q   (rrpv_all),
      .valid_q  (valid_all)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vic_valid <= 1'b0;
         vic_way   <= '0;
      end else begin
         vic_valid <= vq_valid;
         if (vq_valid) vic_way <= pick_way;
      end
   end

endmodule

// File: rtl/rrip_repl_ctrl_chk.sv
module rrip_repl_ctrl_chk #(
   parameter int NUM_SETS = 16,
   parameter int NUM_WAYS = 4,
   parameter int RRPV_W   = 2,
   parameter int PSEL_W   = 10
) (
   input logic                                      clk,
   input logic                                      rst_n,
   input logic [1:0]                                mode_sel,
   input logic                                      upd_valid,
   input logic                                      upd_fill,
   input logic [$clog2(NUM_SETS)-1:0]               upd_set,
   input logic [$clog2(NUM_WAYS)-1:0]               upd_way,
   input logic                                      vq_valid,
   input logic [$clog2(NUM_SETS)-1:0]               vq_set,
   input logic                                      vic_valid,
   input logic [$clog2(NUM_WAYS)-1:0]               vic_way,
   input logic [NUM_SETS-1:0][NUM_WAYS-1:0][RRPV_W-1:0] rrpv_all,
   input logic [NUM_SETS-1:0][NUM_WAYS-1:0]         valid_all,
   input logic [PSEL_W-1:0]                         psel_val
);

   localparam int SET_W = $clog2(NUM_SETS);
   localparam int WAY_W = $clog2(NUM_WAYS);
   localparam logic [RRPV_W-1:0] RRPV_MAX = '1;

   logic [SET_W-1:0] q_set_r;
   logic             q_inv_r;
   logic             q_clash_r;
   logic [SET_W-1:0] u_set_r;
   logic [WAY_W-1:0] u_way_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_set_r   <= '0;
         q_inv_r   <= 1'b0;
         q_clash_r <= 1'b0;
         u_set_r   <= '0;
         u_way_r   <= '0;
      end else begin
         q_set_r   <= vq_set;
         q_inv_r   <= ~&valid_all[vq_set];
         q_clash_r <= upd_valid && (upd_set == vq_set);
         u_set_r   <= upd_set;
         u_way_r   <= upd_way;
      end
   end

   assert_resp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      vq_valid |=> vic_valid);

   assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !vq_valid |=> !vic_valid);

   assert_invalid_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_valid && q_inv_r && !q_clash_r) |-> !valid_all[q_set_r][vic_way]);

   assert_victim_distant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_valid && !q_inv_r && !q_clash_r) |-> (rrpv_all[q_set_r][vic_way] == RRPV_MAX));

   assert_hit_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_fill) |=> (rrpv_all[u_set_r][u_way_r] == '0));

   assert_fill_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_fill) |=>
         (valid_all[u_set_r][u_way_r] && (rrpv_all[u_set_r][u_way_r] >= RRPV_MAX - 1'b1)));

   assert_psel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_valid && upd_fill && (mode_sel == 2'd2)) |=> $stable(psel_val));

endmodule

bind rrip_repl_ctrl rrip_repl_ctrl_chk #(
   .NUM_SETS(NUM_SETS),
   .NUM_WAYS(NUM_WAYS),
   .RRPV_W  (RRPV_W),
   .PSEL_W  (PSEL_W)
) i_rrip_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_sel (mode_sel),
   .upd_valid(upd_valid),
   .upd_fill (upd_fill),
   .upd_set  (upd_set),
   .upd_way  (upd_way),
   .vq_valid (vq_valid),
   .vq_set   (vq_set),
   .vic_valid(vic_valid),
   .vic_way  (vic_way),
   .rrpv_all (rrpv_all),
   .valid_all(valid_all),
   .psel_val (psel_val)
);

// File: tb/test_rrip_repl_ctrl.sv
`timescale 1ns/1ps
module test_rrip_repl_ctrl;

   localparam int NS = 16;
   localparam int NW = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = '0;
   logic       upd_valid = 1'b0;
   logic       upd_fill = 1'b0;
   logic [3:0] upd_set = '0;
   logic [1:0] upd_way = '0;
   logic       vq_valid = 1'b0;
   logic [3:0] vq_set = '0;
   logic       vic_valid;
   logic [1:0] vic_way;

   int  vectors = 0;
   int  miscompares = 0;
   bit  done = 1'b0;

   // reference state
   int  m_rrpv [NS][NW];
   bit  m_valid[NS][NW];
   int  m_psel = 511;
   int  m_bcnt = 0;

   always #2 clk = ~clk;

   rrip_repl_ctrl #(
      .NUM_SETS(NS), .NUM_WAYS(NW), .RRPV_W(2), .PSEL_W(10),
      .BIMODAL_PERIOD(32), .LEADER_SEL_W(3)
   ) i_rrip_repl_ctrl (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
      .upd_valid(upd_valid), .upd_fill(upd_fill), .upd_set(upd_set), .upd_way(upd_way),
      .vq_valid(vq_valid), .vq_set(vq_set),
      .vic_valid(vic_valid), .vic_way(vic_way)
   );

   function automatic bit mdl_bim(int s, int md);
      if (md == 1) return 1'b1;
      if (md == 2) begin
         if (s % 8 == 0) return 1'b0;
         if (s % 8 == 7) return 1'b1;
         return (m_psel >= 512);
      end
      return 1'b0;
   endfunction

   function automatic int mdl_ins(int s, int md);
      if (mdl_bim(s, md)) return (m_bcnt % 32 == 0) ? 2 : 3;
      return 2;
   endfunction

   task automatic mdl_fill_advance(int s, int md);
      if (mdl_bim(s, md)) m_bcnt++;
      if (md == 2) begin
         if (s % 8 == 0 && m_psel < 1023) m_psel++;
         else if (s % 8 == 7 && m_psel > 0) m_psel--;
      end
   endtask

   // repeated aging until some way reaches the distant value
   task automatic mdl_query(int s, output int vw, output bit had_inv);
      bit top;
      had_inv = 1'b0;
      vw = -1;
      for (int w = NW - 1; w >= 0; w--) if (!m_valid[s][w]) begin had_inv = 1'b1; vw = w; end
      if (had_inv) return;
      top = 1'b0;
      while (!top) begin
         for (int w = 0; w < NW; w++) if (m_rrpv[s][w] == 3) top = 1'b1;
         if (!top) for (int w = 0; w < NW; w++) m_rrpv[s][w]++;
      end
      for (int w = NW - 1; w >= 0; w--) if (m_rrpv[s][w] == 3) vw = w;
   endtask

   task automatic step(bit uv, bit uf, int us, int uw, bit qv, int qs, int md, string tag);
      int    exp_w = 0;
      bit    had_inv = 1'b0;
      string t;
      mode_sel  = 2'(md);
      upd_valid = uv;
      upd_fill  = uf;
      upd_set   = 4'(us);
      upd_way   = 2'(uw);
      vq_valid  = qv;
      vq_set    = 4'(qs);
      if (qv) mdl_query(qs, exp_w, had_inv);
      if (uv) begin
         if (uf) begin
            m_rrpv[us][uw] = mdl_ins(us, md);
            m_valid[us][uw] = 1'b1;
            mdl_fill_advance(us, md);
         end else begin
            m_rrpv[us][uw] = 0;
         end
      end
      t = (tag != "") ? tag : (had_inv ? "R3" : "R4");
      @(posedge clk);
      @(negedge clk);
      vectors++;
      if (vic_valid !== qv) begin
         miscompares++;
         $display("FAIL %s R8: vic_valid=%0b expected %0b", t, vic_valid, qv);
      end
      if (qv) begin
         vectors++;
         if (int'(vic_way) !== exp_w) begin
            miscompares++;
            $display("FAIL %s: set %0d vic_way=%0d expected %0d", t, qs, vic_way, exp_w);
         end
      end
   endtask

   task automatic fill_set_all(int s, int md, string tag);
      for (int w = 0; w < NW; w++) step(1, 1, s, w, 0, 0, md, tag);
   endtask

   initial begin
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < NW; w++) begin m_rrpv[s][w] = 3; m_valid[s][w] = 1'b0; end
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      vectors++;
      if (vic_valid !== 1'b0) begin
         miscompares++;
         $display("FAIL R1: vic_valid after reset=%0b expected 0", vic_valid);
      end
      // R1 / R3: empty set gives way 0
      step(0, 0, 0, 0, 1, 3, 0, "R1");
      // R5: static fills, all at 2, aging to 3, way 0
      fill_set_all(3, 0, "R5");
      step(0, 0, 0, 0, 1, 3, 0, "R5");
      // R2: hit way 0 then query picks way 1
      step(1, 0, 3, 0, 0, 0, 0, "R2");
      step(0, 0, 0, 0, 1, 3, 0, "R2");
      step(0, 0, 0, 0, 1, 3, 0, "R4");
      // R3: partly filled set picks lowest invalid
      step(1, 1, 2, 0, 0, 0, 0, "R3");
      step(1, 1, 2, 2, 0, 0, 0, "R3");
      step(0, 0, 0, 0, 1, 2, 0, "R3");
      // R6: bimodal, first fill long, rest distant
      fill_set_all(4, 1, "R6");
      step(0, 0, 0, 0, 1, 4, 0, "R6");
      step(1, 0, 4, 1, 0, 0, 1, "R6");
      step(0, 0, 0, 0, 1, 4, 1, "R6");
      // R9: mode 3 inserts like static
      fill_set_all(5, 3, "R9");
      step(1, 0, 5, 0, 0, 0, 3, "R9");
      step(0, 0, 0, 0, 1, 5, 3, "R9");
      // R7: drive selector up, follower becomes bimodal
      for (int i = 0; i < 40; i++) step(1, 1, 0, i % NW, 0, 0, 2, "R7");
      fill_set_all(9, 2, "R7");
      step(1, 0, 9, 0, 0, 0, 2, "R7");
      step(0, 0, 0, 0, 1, 9, 2, "R7");
      // R7: drive selector down, follower becomes static
      for (int i = 0; i < 100; i++) step(1, 1, 7, i % NW, 0, 0, 2, "R7");
      fill_set_all(10, 2, "R7");
      step(1, 0, 10, 3, 0, 0, 2, "R7");
      step(0, 0, 0, 0, 1, 10, 2, "R7");
      // R7: saturation at 0 from more bimodal-leader fills
      for (int i = 0; i < 500; i++) step(1, 1, 15, i % NW, 0, 0, 2, "R7");
      fill_set_all(11, 2, "R7");
      step(0, 0, 0, 0, 1, 11, 2, "R7");
      // R8: event and query on the same set in one cycle
      step(1, 0, 3, 2, 1, 3, 0, "R8");
      step(1, 1, 2, 1, 1, 2, 0, "R8");
      step(0, 0, 0, 0, 1, 3, 0, "R8");
      step(0, 0, 0, 0, 1, 2, 0, "R8");
      // constrained random mix
      for (int i = 0; i < 6000; i++) begin
         int md = $urandom_range(0, 3);
         bit uv = $urandom_range(0, 1);
         bit uf = ($urandom_range(0, 2) != 0);
         int us = $urandom_range(0, NS - 1);
         int uw = $urandom_range(0, NW - 1);
         bit qv = $urandom_range(0, 1);
         int qs = ($urandom_range(0, 1) != 0) ? us : $urandom_range(0, NS - 1);
         step(uv, uf, us, uw, qv, qs, md, "");
      end
      step(0, 0, 0, 0, 0, 0, 0, "R8");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule